// File: doc/BRIEF.md
# Chip-Select Serial Result Port

This block is the digital side of a single sampling converter whose result is read over a serial line. It is written as a synthesizable emulator of that port. A rising edge on the convert input, taken while the select input is high, starts a conversion. The conversion is timed in system clocks. When it ends, the port captures a result word supplied by a stub timer and holds it.

A falling edge on the active-low select input presents the top result bit at once. Each later falling edge of the serial clock moves the line to the next lower bit. The line is released, which is modelled by clearing an output-enable, at the sixteenth falling clock edge or when select goes back high, whichever comes first.

Convert, select and serial clock arrive asynchronously. Each one is synchronised and edge-detected in the system clock domain before the port uses it.

Top module: `adc_cs_serial_port`

## Requirements
- R1: During reset and after it, with select high, the output enable `sdo_oe_o` is 0 (high impedance).
- R2: A rising edge on `cnv_i` while `sel_n_i` is high starts a conversion lasting `CONV_CYCLES` system clocks. Throughout that time `sdo_oe_o` is 0.
- R3: Outside a conversion and outside a readout, when `sel_n_i` and `cnv_i` are both low, the port drives the line: `sdo_oe_o`=1 and `sdo_o`=0.
- R4: The word on `result_i` is captured when the conversion ends. Later changes to `result_i` do not alter the word that is read out.
- R5: After a conversion, a falling edge on `sel_n_i` drives bit 15 (the most significant bit) of the captured word with `sdo_oe_o`=1. No serial clock edge is needed.
- R6: Each falling edge of `sck_i` during readout presents the next lower bit, so bit 0 is presented after the 15th falling edge. Between falling edges, `sdo_o` does not change.
- R7: The 16th falling edge of `sck_i` in a readout sets `sdo_oe_o` to 0.
- R8: A rising edge on `sel_n_i` during readout sets `sdo_oe_o` to 0 and discards the bits not yet read. A later falling edge on `sel_n_i` does not restart the readout until a new conversion has completed.
- R9: Edges on `sck_i` during a conversion are ignored. The next readout still starts at bit 15.
- R10: A falling edge on `sel_n_i` during a conversion does not start a readout. `sdo_oe_o` stays 0.
- R11: A rising edge on `cnv_i` while `sel_n_i` is low starts no conversion. A later select falling edge produces no readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv_i | input | 1 | Convert line, asynchronous |
| sel_n_i | input | 1 | Active-low select line, asynchronous |
| sck_i | input | 1 | Serial clock line, asynchronous |
| result_i | input | WIDTH | Result word from the conversion stub |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Data line enable; 0 models high impedance |

## Verification
Two functions can land in the same system cycle. One is the release caused by the 16th serial-clock falling edge. The other is the release caused by select returning high. The bench provokes this by changing `sck_i` and `sel_n_i` at the same instant, so that their synchronised edges reach the sequencer together. The result is judged at the ports: the line must go to high impedance, and a following select fall must not restart a readout.

// File: rtl/csp_pkg.sv
// Shared types for the chip-select serial result port.
// Assumes: nothing beyond the consumers importing it.
package csp_pkg;

    // Phase of the port's life cycle between conversions.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,  // no result held since reset
        PH_CONV  = 3'd1,  // conversion running, inputs ignored
        PH_HOLD  = 3'd2,  // result held, waiting for select
        PH_READ  = 3'd3,  // bits being shifted out
        PH_SPENT = 3'd4   // result consumed or abandoned
    } csp_phase_e;

    // Positions of the asynchronous lines in the synchroniser vector.
    localparam int LINE_CNV = 0;
    localparam int LINE_SEL = 1;
    localparam int LINE_SCK = 2;
    localparam int N_LINES  = 3;

endpackage

// File: rtl/csp_sync_edge.sv
// Multi-stage synchroniser for one asynchronous line, plus a delayed copy
// for edge detection.
// Assumes: STAGES >= 2, and the input is held for at least STAGES+1 clocks
// between changes.
module csp_sync_edge #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic lvl_o,
    output logic dly_o
);

    logic [STAGES-1:0] chain_q;
    logic              dly_q;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dly_q <= RST_VAL;
        else        dly_q <= chain_q[STAGES-1];
    end

    assign lvl_o = chain_q[STAGES-1];
    assign dly_o = dly_q;

endmodule

// File: rtl/csp_seq.sv
// Phase sequencer. Starts conversions, times them, opens a readout on the
// select edge and ends it on release.
// Assumes: edge inputs are single-cycle pulses in the clk domain.
module csp_seq
    import csp_pkg::*;
#(
    parameter int CONV_CYCLES = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnv_rise_i,
    input  logic       sel_lvl_i,
    input  logic       sel_rise_i,
    input  logic       sel_fall_i,
    input  logic       sck_fall_i,
    input  logic       last_bit_i,
    output csp_phase_e phase_o,
    output logic       load_o,
    output logic       start_o,
    output logic       shift_o
);

    localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(CONV_CYCLES - 1);

    csp_phase_e    phase_q, phase_d;
    logic [CW-1:0] cnt_q;
    logic          begin_conv;

    // A new conversion is accepted in any resting phase when select is high.
    assign begin_conv = cnv_rise_i && sel_lvl_i &&
                        (phase_q == PH_IDLE || phase_q == PH_HOLD || phase_q == PH_SPENT);

    // Control strobes for the shifter.
    assign load_o  = (phase_q == PH_CONV) && (cnt_q == '0);
    assign start_o = (phase_q == PH_HOLD) && sel_fall_i && !begin_conv;
    assign shift_o = (phase_q == PH_READ) && sck_fall_i && !sel_rise_i && !last_bit_i;

    // Next-phase decision.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE, PH_SPENT: if (begin_conv) phase_d = PH_CONV;
            PH_CONV:           if (cnt_q == '0) phase_d = PH_HOLD;
            PH_HOLD: begin
                if (begin_conv)      phase_d = PH_CONV;
                else if (sel_fall_i) phase_d = PH_READ;
            end
            PH_READ: begin
                if (sel_rise_i)                    phase_d = PH_SPENT;
                else if (sck_fall_i && last_bit_i) phase_d = PH_SPENT;
            end
            default:           phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Conversion timer: loaded on start, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (begin_conv)       cnt_q <= CNT_INIT;
        else if (phase_q == PH_CONV && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/csp_shifter.sv
// Result holding and shift register. Captures the word on load, resets the
// bit position on start, and moves one bit toward the line on each shift.
// Assumes: load, start and shift are mutually exclusive single-cycle strobes.
module csp_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             start_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] word_i,
    output logic             msb_o,
    output logic             last_o
);

    localparam int BW = $clog2(WIDTH);
    localparam logic [BW-1:0] LAST_POS = BW'(WIDTH - 1);

    logic [WIDTH-1:0] shreg_q;
    logic [BW-1:0]    pos_q;

    // Capture the word at end of conversion, or move it one bit on shift.
    always_ff @(posedge clk) begin
        if (!rst_n)       shreg_q <= '0;
        else if (load_i)  shreg_q <= word_i;
        else if (shift_i) shreg_q <= {shreg_q[WIDTH-2:0], 1'b0};
    end

    // Track how many bits have already left the line.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pos_q <= '0;
        else if (load_i || start_i) pos_q <= '0;
        else if (shift_i)           pos_q <= pos_q + 1'b1;
    end

    assign msb_o  = shreg_q[WIDTH-1];
    assign last_o = (pos_q == LAST_POS);

endmodule

// File: rtl/adc_cs_serial_port.sv
// Top of the chip-select serial result port. Synchronises the three
// asynchronous lines, sequences conversion and readout, and forms the data
// line value and enable.
// Assumes: lines are held steady for several system clocks between changes.
module adc_cs_serial_port
    import csp_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int CONV_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnv_i,
    input  logic             sel_n_i,
    input  logic             sck_i,
    input  logic [WIDTH-1:0] result_i,
    output logic             sdo_o,
    output logic             sdo_oe_o
);

    logic [N_LINES-1:0] raw, lvl, dly;
    logic               cnv_rise, sel_rise, sel_fall, sck_fall;
    logic               load, start, shift, last_bit, msb;
    csp_phase_e         phase;

    assign raw[LINE_CNV] = cnv_i;
    assign raw[LINE_SEL] = sel_n_i;
    assign raw[LINE_SCK] = sck_i;

    // One synchroniser per line; select resets high (deselected).
    for (genvar i = 0; i < N_LINES; i++) begin : g_sync
        csp_sync_edge #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(i == LINE_SEL)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (raw[i]),
            .lvl_o(lvl[i]),
            .dly_o(dly[i])
        );
    end

    assign cnv_rise = lvl[LINE_CNV] && !dly[LINE_CNV];
    assign sel_rise = lvl[LINE_SEL] && !dly[LINE_SEL];
    assign sel_fall = !lvl[LINE_SEL] && dly[LINE_SEL];
    assign sck_fall = !lvl[LINE_SCK] && dly[LINE_SCK];

    csp_seq #(
        .CONV_CYCLES(CONV_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnv_rise_i(cnv_rise),
        .sel_lvl_i (lvl[LINE_SEL]),
        .sel_rise_i(sel_rise),
        .sel_fall_i(sel_fall),
        .sck_fall_i(sck_fall),
        .last_bit_i(last_bit),
        .phase_o   (phase),
        .load_o    (load),
        .start_o   (start),
        .shift_o   (shift)
    );

    csp_shifter #(
        .WIDTH(WIDTH)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .start_i(start),
        .shift_i(shift),
        .word_i (result_i),
        .msb_o  (msb),
        .last_o (last_bit)
    );

    // Line value: the current bit during readout, otherwise a driven low
    // only when both select and convert are low outside a conversion.
    always_comb begin
        if (phase == PH_READ) begin
            sdo_oe_o = 1'b1;
            sdo_o    = msb;
        end else begin
            sdo_oe_o = (phase != PH_CONV) && !lvl[LINE_SEL] && !lvl[LINE_CNV];
            sdo_o    = 1'b0;
        end
    end

endmodule

// File: rtl/adc_cs_serial_port_chk.sv
// Temporal checks for the chip-select serial result port, bound to the top.
// Assumes: internal phase and edge strobes are visible in the top's scope.
module adc_cs_serial_port_chk
    import csp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input csp_phase_e phase,
    input logic       sel_rise,
    input logic       sel_fall,
    input logic       sck_fall,
    input logic       last_bit,
    input logic       sdo_o,
    input logic       sdo_oe_o
);

    // R2
    conv_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV) |-> !sdo_oe_o);

    // R10
    conv_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV && sel_fall) |=> (phase != PH_READ));

    // R6
    hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ && !sck_fall && !sel_rise) |=> $stable(sdo_o));

    // R7
    last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ && sck_fall && last_bit) |=> !sdo_oe_o);

    // R8
    sel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ && sel_rise) |=> (phase == PH_SPENT && !sdo_oe_o));

    // R5
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ) |-> sdo_oe_o);

endmodule

bind adc_cs_serial_port adc_cs_serial_port_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .sel_rise(sel_rise),
    .sel_fall(sel_fall),
    .sck_fall(sck_fall),
    .last_bit(last_bit),
    .sdo_o   (sdo_o),
    .sdo_oe_o(sdo_oe_o)
);

// File: tb/adc_cs_serial_port_tb_top.sv
// Scoreboard bench: driver steps push expected line states, a monitor pops
// and compares them against the ports.
module adc_cs_serial_port_tb_top;

    localparam int WIDTH  = 16;
    localparam int CONV   = 40;
    localparam int SETTLE = 5;

    typedef struct {
        bit    oe;
        bit    sdo;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnv = 1'b0;
    logic             sel_n = 1'b1;
    logic             sck = 1'b0;
    logic [WIDTH-1:0] result = '0;
    logic             sdo, sdo_oe;

    int   n_total = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];
    event chk_ev;

    always #5 clk = ~clk;

    adc_cs_serial_port #(
        .WIDTH(WIDTH), .CONV_CYCLES(CONV), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sel_n_i(sel_n),
        .sck_i(sck), .result_i(result), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_line(input bit oe, input bit d, input string req);
        exp_t e;
        e.oe = oe; e.sdo = d; e.req = req;
        sb_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    // One serial clock pulse, falling edge at the end, then settle.
    task automatic sck_pulse();
        sck = 1'b1; step(SETTLE);
        sck = 1'b0; step(SETTLE);
    endtask

    task automatic convert(input logic [WIDTH-1:0] w);
        cnv = 1'b0; result = w; step(SETTLE);
        cnv = 1'b1; step(CONV + 2 * SETTLE);
    endtask

    // Monitor: pops each expectation and compares it with the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_total++;
                if (sdo_oe !== e.oe || (e.oe && sdo !== e.sdo)) begin
                    n_fail++;
                    $display("FAIL %s: oe/sdo got %0b/%0b expected %0b/%0b",
                             e.req, sdo_oe, sdo, e.oe, e.sdo);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [WIDTH-1:0] w;
        step(3);
        expect_line(1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1; step(SETTLE);
        expect_line(1'b0, 1'b0, "R1 after reset");

        // R3 idle drive-low
        sel_n = 1'b0; step(SETTLE);
        expect_line(1'b1, 1'b0, "R3 idle sel/cnv low");
        sel_n = 1'b1; step(SETTLE);

        // Conversion with clock and select activity inside it (R2 R9 R10)
        w = 16'hA5C3; result = w;
        cnv = 1'b1; step(SETTLE);
        expect_line(1'b0, 1'b0, "R2 converting");
        sck_pulse(); sck_pulse();
        sel_n = 1'b0; step(SETTLE);
        expect_line(1'b0, 1'b0, "R10 sel low in conversion");
        sel_n = 1'b1;
        step(CONV + 2 * SETTLE);
        result = 16'h0000;  // R4: must not affect readout
        sel_n = 1'b0; step(SETTLE);
        expect_line(1'b1, w[15], "R5 R9 R4 msb on sel fall");
        for (int i = 1; i < WIDTH; i++) begin
            sck_pulse();
            expect_line(1'b1, w[15-i], "R6 next bit");
        end
        sck_pulse();
        expect_line(1'b0, 1'b0, "R7 released after 16th fall");
        sel_n = 1'b1; step(SETTLE);

        // Early select release (R8)
        w = 16'h3C96; convert(w);
        sel_n = 1'b0; step(SETTLE);
        expect_line(1'b1, w[15], "R5 msb second word");
        for (int i = 1; i <= 4; i++) begin
            sck_pulse();
            expect_line(1'b1, w[15-i], "R6 partial read");
        end
        sel_n = 1'b1; step(SETTLE);
        expect_line(1'b0, 1'b0, "R8 released by sel rise");
        sel_n = 1'b0; step(SETTLE);
        expect_line(1'b0, 1'b0, "R8 no reread");
        sel_n = 1'b1; step(SETTLE);

        // Simultaneous 16th fall and select rise (R7 R8)
        w = 16'h8001; convert(w);
        sel_n = 1'b0; step(SETTLE);
        for (int i = 1; i < WIDTH; i++) begin
            sck_pulse();
        end
        expect_line(1'b1, w[0], "R6 bit0 last");
        sck = 1'b1; step(SETTLE);
        sck = 1'b0; sel_n = 1'b1; step(SETTLE);
        expect_line(1'b0, 1'b0, "R7 R8 coincident release");
        sel_n = 1'b0; step(SETTLE);
        expect_line(1'b0, 1'b0, "R8 no reread after coincident release");
        sel_n = 1'b1; step(SETTLE);

        // Convert edge with select low is ignored (R11)
        cnv = 1'b0; step(SETTLE);
        sel_n = 1'b0; step(SETTLE);
        expect_line(1'b1, 1'b0, "R3 drive low after readout");
        result = 16'hFFFF;
        cnv = 1'b1; step(SETTLE);
        expect_line(1'b0, 1'b0, "R11 cnv high sel low no drive");
        step(CONV + 2 * SETTLE);
        sel_n = 1'b1; step(SETTLE);
        sel_n = 1'b0; step(SETTLE);
        expect_line(1'b0, 1'b0, "R11 no conversion started");

        step(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule